// File: doc/BRIEF.md
# Keyed Worker Slot Pool Manager

This block gives a set of identical hardware workers the appearance of being created on demand. Every request that arrives on a valid/ready channel carries a full object key, a method code and a payload. If no slot currently holds that key, the manager claims the lowest-numbered free slot, records the key there and strobes the slot's one-cycle init line alongside the first payload it hands over. Every later request with the same key is steered to that same slot.

A worker gives its slot back with a one-cycle release pulse. It may do so while its own pipeline is still finishing the previous job, so the freed slot can take a new key at once. When every slot is held and a request names an unknown key, the manager drops ready and raises a pool-full flag. Requests for keys that are already held still pass. A debug count reports how many slots are held.

Top module: `slot_pool_mgr`

## Requirements
- R1: After reset no slot holds a key. `occupied` is 0, `pool_full` is 0, `req_ready` is 1, and all `slot_valid` and `slot_init` bits are 0.
- R2: An accepted request whose key is held by no slot claims the lowest-numbered free slot. In the next cycle that slot's bit is 1 in both `slot_valid` and `slot_init`, and the request's method and payload appear on `slot_meth` and `slot_data`. The worker must apply init before it consumes that payload.
- R3: An accepted request whose key is held is delivered in the next cycle to the holding slot, with `slot_init` all 0.
- R4: Keys match only when all ID_W bits are equal. Two keys that differ only in the top bit are bound to different slots.
- R5: A release pulse on a held slot frees it at the clock edge. A later request for the old key is treated as new: it claims a slot and strobes init.
- R6: When no slot is free, `pool_full` is 1, and a request with an unheld key sees `req_ready` 0 and produces no slot output. A request with a held key still sees `req_ready` 1 and is delivered.
- R7: A release and a claim in the same cycle both take effect. The claim never takes the slot that is being released in that cycle. A request whose key matches a slot released in that same cycle counts as unheld.
- R8: `occupied` equals the number of slots holding a key, updated one cycle after each claim or release.
- R9: A release pulse on a slot that holds no key has no effect. `occupied` is unchanged.
- R10: Slot outputs appear exactly one cycle after an accepted request. With `req_valid` low, no `slot_valid` bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_id | input | ID_W | Full object key |
| req_meth | input | METH_W | Method code |
| req_data | input | DATA_W | Payload |
| slot_valid | output | NUM_SLOTS | One-hot delivery strobe per slot |
| slot_init | output | NUM_SLOTS | Init strobe, raised with a slot's first payload |
| slot_meth | output | METH_W | Delivered method code |
| slot_data | output | DATA_W | Delivered payload |
| slot_release | input | NUM_SLOTS | Per-slot release pulse from the workers |
| pool_full | output | 1 | No slot is free |
| occupied | output | $clog2(NUM_SLOTS+1) | Count of held slots (debug) |

## Verification
The bench targets keys that differ only in their top bit. A design that compares a truncated key would send the second key to the first key's slot without an init strobe. It fills the pool and checks that an unknown key is held back while a known key still gets through. A manager that stalls the whole channel, or one that overwrites a held slot, would fail these checks. It pulses a release in the same cycle as a request for the key being freed. A design that reused the freed slot would pick the lower slot, and one that kept the stale match would skip the init strobe. The bench also pulses a release on an empty slot, where a faulty counter would change.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int MAX_SLOTS = 64;

  // isolate the lowest set bit of a vector
  function automatic logic [MAX_SLOTS-1:0] first_set(input logic [MAX_SLOTS-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // number of set bits
  function automatic int unsigned count_set(input logic [MAX_SLOTS-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_SLOTS; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/slot_cam.sv
module slot_cam #(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ID_W-1:0]      look_id,
  input  logic [NUM_SLOTS-1:0] rel_vec,
  input  logic                 wr_en,
  input  logic [NUM_SLOTS-1:0] wr_onehot,
  output logic [NUM_SLOTS-1:0] bound_vec,
  output logic [NUM_SLOTS-1:0] hit_vec
);
  logic [ID_W-1:0] tag [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_entry
    logic wr_here;
    assign wr_here = wr_en & wr_onehot[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bound_vec[s] <= 1'b0;
        tag[s]       <= '0;
      end else begin
        if (wr_here) begin
          bound_vec[s] <= 1'b1;
          tag[s]       <= look_id;
        end else if (rel_vec[s]) begin
          bound_vec[s] <= 1'b0;
        end
      end
    end

    // a slot being released this cycle no longer answers for its key
    assign hit_vec[s] = bound_vec[s] & ~rel_vec[s] & (tag[s] == look_id);
  end

  // R4: a full key lives in at most one slot
  p_unique_bind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7: a claim never lands on a slot that is still held
  p_no_reuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_onehot & bound_vec) == '0));
endmodule

// File: rtl/slot_pick.sv
module slot_pick
  import slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] bound_vec,
  output logic [NUM_SLOTS-1:0] grant_onehot,
  output logic                 any_free
);
  logic [MAX_SLOTS-1:0] free_wide;
  logic [MAX_SLOTS-1:0] grant_wide;

  always_comb begin
    free_wide = '0;
    free_wide[NUM_SLOTS-1:0] = ~bound_vec;
    grant_wide = first_set(free_wide);
  end

  assign grant_onehot = grant_wide[NUM_SLOTS-1:0];
  assign any_free     = |free_wide;
endmodule

// File: rtl/slot_drive.sv
module slot_drive #(
  parameter int NUM_SLOTS = 4,
  parameter int METH_W    = 2,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 fresh,
  input  logic [NUM_SLOTS-1:0] tgt_onehot,
  input  logic [METH_W-1:0]    in_meth,
  input  logic [DATA_W-1:0]    in_data,
  output logic [NUM_SLOTS-1:0] out_valid,
  output logic [NUM_SLOTS-1:0] out_init,
  output logic [METH_W-1:0]    out_meth,
  output logic [DATA_W-1:0]    out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_init  <= '0;
      out_meth  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= accept ? tgt_onehot : '0;
      out_init  <= (accept && fresh) ? tgt_onehot : '0;
      if (accept) begin
        out_meth <= in_meth;
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/slot_pool_mgr.sv
module slot_pool_mgr
  import slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 12,
  parameter int METH_W    = 2,
  parameter int DATA_W    = 16,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_id,
  input  logic [METH_W-1:0]    req_meth,
  input  logic [DATA_W-1:0]    req_data,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic [NUM_SLOTS-1:0] slot_init,
  output logic [METH_W-1:0]    slot_meth,
  output logic [DATA_W-1:0]    slot_data,
  input  logic [NUM_SLOTS-1:0] slot_release,
  output logic                 pool_full,
  output logic [CNT_W-1:0]     occupied
);
  // named internal events
  logic [NUM_SLOTS-1:0] bound_vec;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] grant_onehot;
  logic [NUM_SLOTS-1:0] tgt_onehot;
  logic                 any_free;
  logic                 is_hit;
  logic                 accept;
  logic                 do_claim;
  logic [MAX_SLOTS-1:0] bound_wide;

  slot_cam #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_id   (req_id),
    .rel_vec   (slot_release),
    .wr_en     (do_claim),
    .wr_onehot (grant_onehot),
    .bound_vec (bound_vec),
    .hit_vec   (hit_vec)
  );

  slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .bound_vec    (bound_vec),
    .grant_onehot (grant_onehot),
    .any_free     (any_free)
  );

  assign is_hit     = |hit_vec;
  assign req_ready  = is_hit | any_free;
  assign accept     = req_valid & req_ready;
  assign do_claim   = accept & ~is_hit;
  assign tgt_onehot = is_hit ? hit_vec : grant_onehot;
  assign pool_full  = ~any_free;

  slot_drive #(.NUM_SLOTS(NUM_SLOTS), .METH_W(METH_W), .DATA_W(DATA_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .fresh      (do_claim),
    .tgt_onehot (tgt_onehot),
    .in_meth    (req_meth),
    .in_data    (req_data),
    .out_valid  (slot_valid),
    .out_init   (slot_init),
    .out_meth   (slot_meth),
    .out_data   (slot_data)
  );

  always_comb begin
    bound_wide = '0;
    bound_wide[NUM_SLOTS-1:0] = bound_vec;
    occupied = CNT_W'(count_set(bound_wide));
  end

  // R6: unknown key with a full pool is held back
  p_hold_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pool_full && !is_hit) |-> !req_ready);

  // R10: every acceptance yields exactly one delivery next cycle
  p_deliver_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ($countones(slot_valid) == 1));

  // R10: no acceptance, no delivery
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (slot_valid == '0));

  // R3: a held key never strobes init
  p_no_init_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_hit) |=> (slot_init == '0));

  // R8: count stays in range
  p_occ_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occupied <= CNT_W'(NUM_SLOTS));
endmodule

// File: tb/tb_slot_pool_mgr.sv
module tb_slot_pool_mgr;
  localparam int N  = 4;
  localparam int IW = 12;
  localparam int MW = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [IW-1:0] req_id;
  logic [MW-1:0] req_meth;
  logic [DW-1:0] req_data;
  logic [N-1:0] slot_valid, slot_init, slot_release;
  logic [MW-1:0] slot_meth;
  logic [DW-1:0] slot_data;
  logic pool_full;
  logic [2:0] occupied;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  slot_pool_mgr #(.NUM_SLOTS(N), .ID_W(IW), .METH_W(MW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_meth(req_meth), .req_data(req_data),
    .slot_valid(slot_valid), .slot_init(slot_init), .slot_meth(slot_meth),
    .slot_data(slot_data), .slot_release(slot_release),
    .pool_full(pool_full), .occupied(occupied)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; expect delivery to slot exp_slot, init per exp_init
  task automatic send(input string req, input logic [IW-1:0] id, input int exp_slot,
                      input bit exp_init, input int exp_occ);
    logic [DW-1:0] d;
    d = DW'(id) ^ 16'h5a00;
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_meth = id[1:0]; req_data = d;
    #2 chk({req, " ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, int'(slot_valid), 1 << exp_slot);
    chk({req, " init"}, int'(slot_init), exp_init ? (1 << exp_slot) : 0);
    chk({req, " data"}, int'(slot_data), int'(d));
    chk({req, " meth"}, int'(slot_meth), int'(id[1:0]));
    chk({req, " occupied"}, int'(occupied), exp_occ);
  endtask

  task automatic release_slot(input string req, input int s, input int exp_occ);
    @(negedge clk);
    slot_release = N'(1 << s);
    @(negedge clk);
    slot_release = '0;
    chk({req, " occupied after release"}, int'(occupied), exp_occ);
  endtask

  task automatic t_reset;
    chk("R1 occupied", int'(occupied), 0);
    chk("R1 pool_full", int'(pool_full), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 valid", int'(slot_valid), 0);
    chk("R1 init", int'(slot_init), 0);
  endtask

  task automatic t_bind;
    send("R2 first key", 12'h010, 0, 1, 1);
    send("R2 second key", 12'h011, 1, 1, 2);
    send("R3 repeat key", 12'h010, 0, 0, 2);
    send("R4 top bit differs", 12'h810, 2, 1, 3);
    send("R3 repeat key 2", 12'h011, 1, 0, 3);
  endtask

  task automatic t_full;
    send("R2 fill last", 12'h020, 3, 1, 4);
    @(negedge clk);
    chk("R6 pool_full", int'(pool_full), 1);
    req_valid = 1'b1; req_id = 12'h030; req_meth = 2'd0; req_data = 16'h1111;
    #2 chk("R6 unknown held", int'(req_ready), 0);
    @(negedge clk);
    chk("R6 no delivery", int'(slot_valid), 0);
    chk("R10 still held", int'(req_ready), 0);
    req_valid = 1'b0;
    send("R6 held key passes", 12'h010, 0, 0, 4);
  endtask

  task automatic t_overlap;
    // full pool: release slot1 together with an unknown key; no other slot free
    @(negedge clk);
    slot_release = 4'b0010;
    req_valid = 1'b1; req_id = 12'h030; req_meth = 2'd0; req_data = 16'h2222;
    #2 chk("R7 freed slot not reusable same cycle", int'(req_ready), 0);
    @(negedge clk);
    slot_release = '0; req_valid = 1'b0;
    chk("R7 no delivery", int'(slot_valid), 0);
    chk("R7 release taken", int'(occupied), 3);
    send("R5 rebind freed slot", 12'h030, 1, 1, 4);
    // slots: 0=010 1=030 2=810 3=020
    release_slot("R5", 3, 3);
    // release slot2 and ask for its old key in the same cycle
    @(negedge clk);
    slot_release = 4'b0100;
    req_valid = 1'b1; req_id = 12'h810; req_meth = 2'd2; req_data = 16'h3333;
    #2 chk("R7 ready", int'(req_ready), 1);
    @(negedge clk);
    slot_release = '0; req_valid = 1'b0;
    chk("R7 claim skips freed slot2", int'(slot_valid), 4'b1000);
    chk("R7 stale match gives init", int'(slot_init), 4'b1000);
    chk("R8 occupied", int'(occupied), 3);
    send("R5 old key reclaims", 12'h020, 2, 1, 4);
  endtask

  task automatic t_idle_release;
    release_slot("R8", 2, 3);
    release_slot("R9 empty slot", 2, 3);
    chk("R6 pool_full cleared", int'(pool_full), 0);
    @(negedge clk);
    chk("R10 idle no delivery", int'(slot_valid), 0);
    send("R2 lowest free", 12'h055, 2, 1, 4);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_meth = '0; req_data = '0;
    slot_release = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bind();
    t_full();
    t_overlap();
    t_idle_release();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule